// File: doc/BRIEF.md
# Multi-Polynomial CRC Register Engine

This block is a memory-mapped checksum engine. It sits on a simple single-cycle register bus. The bus master may be a processor or a DMA engine that shares the same write port. Each write to the data register folds one word into a running checksum in the same cycle. The word is 8, 16 or 32 bits wide, as chosen in the control register. The checksum is always up to date on the cycle after the write, so back-to-back writes are absorbed at one per clock.

Software picks one of four polynomials. On the input side it can complement the data and reverse the bits within each byte. On readback it can reverse and complement the checksum. A self-clearing command in the control register copies the seed register into the checksum, which starts a new calculation. Reads are combinational: the read data follows the address in the same cycle.

Top module: `crc_regs_engine`

## Requirements
- R1: Registers are decoded at byte offsets 0x0 (control), 0x4 (data, reads as zero), 0x8 (seed) and 0xC (checksum). After reset the control, seed and checksum registers all read as zero.
- R2: The seed register reads back the last value written to it. A write to offset 0xC leaves the checksum unchanged.
- R3: Writing control with bit 1 set loads the checksum from the seed, masked to the width of the polynomial selected by that same write. Bit 1 always reads back as 0.
- R4: A data write is ignored while the enable bit (control bit 0) is 0.
- R5: Control bits [31:30] select the polynomial. 00 selects a 16-bit polynomial 0x1021, 01 an 8-bit polynomial 0x07, 10 a 16-bit polynomial 0x8005 and 11 a 32-bit polynomial 0x04C11DB7. Shifting is MSB first, with no implicit input or output inversion.
- R6: Control bits [29:28] set the data length: 00 uses data bits [7:0], 01 uses [15:0], and 1x uses all 32 bits. The used bytes are fed most significant first.
- R7: Control bit 26 complements the truncated data. Control bit 24 reverses the bits within each byte of it. For example, 0xAABBCCDD with reversal gives the same checksum as 0x55DD33BB without it.
- R8: Control bit 25 presents the checksum bit-reversed over the polynomial width. For example, 0xDD7B0F2E reads as 0x74F0DEBB in the 32-bit mode.
- R9: Control bit 27 presents the checksum complemented over the polynomial width. Bits above the width always read as zero.
- R10: Data writes on consecutive cycles are each folded in, with no lost or stalled word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 4-bit address and the four standard polynomials. These defaults make the published check values for the nine-character string "123456789" apply directly: 0x0376E6E7, 0x29B1, 0xFEE8 and 0xF4, plus the complemented 32-bit value 0xFC891918. They also allow the same string to be fed as whole words and as single bytes, and compared. A behavioural reference model checks the checksum readback on every idle clock.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

   typedef enum logic [1:0] {
      MODE_CCITT = 2'b00,
      MODE_C8    = 2'b01,
      MODE_C16   = 2'b10,
      MODE_C32   = 2'b11
   } crc_mode_e;

   localparam int CTL_EN      = 0;
   localparam int CTL_LOAD    = 1;
   localparam int CTL_INREV   = 24;
   localparam int CTL_OUTREV  = 25;
   localparam int CTL_INCPL   = 26;
   localparam int CTL_OUTCPL  = 27;
   localparam int CTL_LEN_LSB = 28;
   localparam int CTL_MOD_LSB = 30;

   function automatic int unsigned mode_width(input crc_mode_e m);
      case (m)
         MODE_C8:  return 8;
         MODE_C32: return 32;
         default:  return 16;
      endcase
   endfunction

   function automatic logic [31:0] width_mask(input int unsigned w);
      if (w >= 32) return 32'hFFFF_FFFF;
      return (32'h1 << w) - 32'h1;
   endfunction

   function automatic int unsigned len_bytes(input logic [1:0] l);
      if (l[1]) return 4;
      if (l[0]) return 2;
      return 1;
   endfunction

   // fold one byte, MSB first, into a state of width w
   function automatic logic [31:0] crc_byte(input logic [31:0] st,
                                            input logic [7:0]  b,
                                            input logic [31:0] poly,
                                            input int unsigned w);
      logic [31:0] s;
      logic        fb;
      s = st;
      for (int i = 7; i >= 0; i--) begin
         fb = s[w-1] ^ b[i];
         s  = s << 1;
         if (fb) s = s ^ poly;
      end
      return s & width_mask(w);
   endfunction

endpackage

// File: rtl/crc_in_prep.sv
module crc_in_prep #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] din,
   input  logic [1:0]    len,
   input  logic          cpl,
   input  logic          rev,
   output logic [DW-1:0] dout
);
   localparam int NB = DW / 8;

   logic [DW-1:0] len_mask;
   logic [DW-1:0] cw;

   always_comb begin
      case (crc_eng_pkg::len_bytes(len))
         1:       len_mask = DW'(32'h0000_00FF);
         2:       len_mask = DW'(32'h0000_FFFF);
         default: len_mask = '1;
      endcase
      cw = cpl ? ~(din & len_mask) : (din & len_mask);
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      for (genvar i = 0; i < 8; i++) begin : g_bit
         assign dout[b*8+i] = rev ? cw[b*8+7-i] : cw[b*8+i];
      end
   end

endmodule

// File: rtl/crc_fold.sv
module crc_fold #(
   parameter int          DW         = 32,
   parameter logic [31:0] POLY_CCITT = 32'h0000_1021,
   parameter logic [31:0] POLY_C8    = 32'h0000_0007,
   parameter logic [31:0] POLY_C16   = 32'h0000_8005,
   parameter logic [31:0] POLY_C32   = 32'h04C1_1DB7
) (
   input  logic [31:0]             state,
   input  logic [DW-1:0]           word,
   input  crc_eng_pkg::crc_mode_e  mode,
   input  logic [1:0]              len,
   output logic [31:0]             next
);
   import crc_eng_pkg::*;
   localparam int NB = DW / 8;

   logic [31:0]         poly;
   int unsigned         w;
   int unsigned         nused;
   logic [NB:0][31:0]   chain;

   always_comb begin
      case (mode)
         MODE_C8:  poly = POLY_C8;
         MODE_C16: poly = POLY_C16;
         MODE_C32: poly = POLY_C32;
         default:  poly = POLY_CCITT;
      endcase
      w     = mode_width(mode);
      nused = len_bytes(len);
   end

   assign chain[0] = state;

   // stage k handles byte NB-1-k; bytes above the length pass through
   for (genvar k = 0; k < NB; k++) begin : g_stage
      localparam int IDX = NB - 1 - k;
      assign chain[k+1] = (IDX < nused) ?
                          crc_byte(chain[k], word[IDX*8 +: 8], poly, w) :
                          chain[k];
   end

   assign next = chain[NB];

endmodule

// File: rtl/crc_out_fmt.sv
module crc_out_fmt (
   input  logic [31:0]            state,
   input  crc_eng_pkg::crc_mode_e mode,
   input  logic                   rev,
   input  logic                   cpl,
   output logic [31:0]            value
);
   import crc_eng_pkg::*;

   int unsigned w;
   logic [31:0] msk;
   logic [31:0] v;
   logic [31:0] r;

   always_comb begin
      w   = mode_width(mode);
      msk = width_mask(w);
      v   = state & msk;
      r   = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < int'(w)) r[i] = v[int'(w)-1-i];
      end
      if (rev) v = r;
      if (cpl) v = ~v & msk;
      value = v;
   end

endmodule

// File: rtl/crc_regs_engine.sv
module crc_regs_engine #(
   parameter int          DW         = 32,
   parameter int          AW         = 4,
   parameter logic [31:0] POLY_CCITT = 32'h0000_1021,
   parameter logic [31:0] POLY_C8    = 32'h0000_0007,
   parameter logic [31:0] POLY_C16   = 32'h0000_8005,
   parameter logic [31:0] POLY_C32   = 32'h04C1_1DB7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata
);
   import crc_eng_pkg::*;

   localparam logic [AW-1:0] OFF_CTL  = AW'(4'h0);
   localparam logic [AW-1:0] OFF_DAT  = AW'(4'h4);
   localparam logic [AW-1:0] OFF_SEED = AW'(4'h8);
   localparam logic [AW-1:0] OFF_SUM  = AW'(4'hC);

   if (DW != 32) begin : g_bad_dw
      $error("crc_regs_engine: DW must be 32");
   end
   if (AW < 4) begin : g_bad_aw
      $error("crc_regs_engine: AW must be at least 4");
   end
   if (POLY_C8 > 32'hFF || POLY_CCITT > 32'hFFFF || POLY_C16 > 32'hFFFF) begin : g_bad_poly
      $error("crc_regs_engine: polynomial wider than its mode");
   end

   logic        en_q, inrev_q, outrev_q, incpl_q, outcpl_q;
   logic [1:0]  len_q;
   crc_mode_e   mode_q;
   logic [31:0] seed_q;
   logic [31:0] crc_q;

   logic        wr_ctl, wr_dat, wr_seed;
   crc_mode_e   new_mode;
   logic [31:0] prep_word;
   logic [31:0] fold_next;
   logic [31:0] sum_view;
   wire         unused_ctl_bits = ^bus_wdata[23:2];

   assign wr_ctl   = bus_sel && bus_wr && (bus_addr == OFF_CTL);
   assign wr_dat   = bus_sel && bus_wr && (bus_addr == OFF_DAT);
   assign wr_seed  = bus_sel && bus_wr && (bus_addr == OFF_SEED);
   assign new_mode = crc_mode_e'(bus_wdata[CTL_MOD_LSB +: 2]);

   crc_in_prep #(.DW(DW)) u_prep (
      .din  (bus_wdata),
      .len  (len_q),
      .cpl  (incpl_q),
      .rev  (inrev_q),
      .dout (prep_word)
   );

   crc_fold #(
      .DW(DW), .POLY_CCITT(POLY_CCITT), .POLY_C8(POLY_C8),
      .POLY_C16(POLY_C16), .POLY_C32(POLY_C32)
   ) u_fold (
      .state (crc_q),
      .word  (prep_word),
      .mode  (mode_q),
      .len   (len_q),
      .next  (fold_next)
   );

   crc_out_fmt u_fmt (
      .state (crc_q),
      .mode  (mode_q),
      .rev   (outrev_q),
      .cpl   (outcpl_q),
      .value (sum_view)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         inrev_q  <= 1'b0;
         outrev_q <= 1'b0;
         incpl_q  <= 1'b0;
         outcpl_q <= 1'b0;
         len_q    <= 2'b00;
         mode_q   <= MODE_CCITT;
         seed_q   <= '0;
         crc_q    <= '0;
      end else begin
         if (wr_ctl) begin
            en_q     <= bus_wdata[CTL_EN];
            inrev_q  <= bus_wdata[CTL_INREV];
            outrev_q <= bus_wdata[CTL_OUTREV];
            incpl_q  <= bus_wdata[CTL_INCPL];
            outcpl_q <= bus_wdata[CTL_OUTCPL];
            len_q    <= bus_wdata[CTL_LEN_LSB +: 2];
            mode_q   <= new_mode;
            if (bus_wdata[CTL_LOAD])
               crc_q <= seed_q & width_mask(mode_width(new_mode));
         end
         if (wr_seed) seed_q <= bus_wdata;
         if (wr_dat && en_q) crc_q <= fold_next;
      end
   end

   always_comb begin
      case (bus_addr)
         OFF_CTL:  bus_rdata = {mode_q, len_q, outcpl_q, incpl_q, outrev_q,
                                inrev_q, 22'b0, 1'b0, en_q};
         OFF_SEED: bus_rdata = seed_q;
         OFF_SUM:  bus_rdata = sum_view;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/crc_regs_engine_chk.sv
module crc_regs_engine_chk #(
   parameter int DW = 32,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_sel,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic [DW-1:0] bus_rdata,
   input logic          en_q,
   input logic [1:0]    mode_q,
   input logic [31:0]   seed_q,
   input logic [31:0]   crc_q
);
   logic wr_any;
   assign wr_any = bus_sel && bus_wr;

   // R4: data write while disabled leaves the checksum alone
   a_r4_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && bus_addr == AW'(4'h4) && !en_q) |=> $stable(crc_q));

   // R2: write to the checksum offset has no effect
   a_r2_sum_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && bus_addr == AW'(4'hC)) |=> $stable(crc_q));

   // R2: seed only changes on a seed write
   a_r2_seed_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_any && bus_addr == AW'(4'h8)) |=> $stable(seed_q));

   // R3: reload in 32-bit mode copies the seed
   a_r3_reload_seed: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && bus_addr == AW'(4'h0) && bus_wdata[1] && bus_wdata[31:30] == 2'b11)
      |=> crc_q == $past(seed_q));

   // R3: the reload bit never reads back as 1
   a_r3_load_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == AW'(4'h0)) |-> !bus_rdata[1]);

   // R9: upper bits read zero in the 8-bit mode
   a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01 && bus_addr == AW'(4'hC)) |-> bus_rdata[31:8] == '0);

endmodule

bind crc_regs_engine crc_regs_engine_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .en_q      (en_q),
   .mode_q    (mode_q),
   .seed_q    (seed_q),
   .crc_q     (crc_q)
);

// File: tb/crc_regs_engine_tb_top.sv
`timescale 1ns/1ps
module crc_regs_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'hC;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   bit          m_en, m_irev, m_orev, m_icpl, m_ocpl;
   int          m_len, m_mode;
   logic [31:0] m_seed = '0, m_crc = '0;
   logic [31:0] saved;

   always #4 clk = ~clk;

   crc_regs_engine dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   function automatic int mw(int m);
      return (m == 1) ? 8 : (m == 3) ? 32 : 16;
   endfunction

   function automatic logic [31:0] mpoly(int m);
      case (m)
         0: return 32'h1021;
         1: return 32'h07;
         2: return 32'h8005;
         default: return 32'h04C11DB7;
      endcase
   endfunction

   function automatic logic [31:0] mmask(int w);
      longint one = 1;
      return 32'((one << w) - 1);
   endfunction

   function automatic logic [31:0] model_fold(logic [31:0] st, logic [31:0] d);
      int nb = (m_len >= 2) ? 4 : (m_len == 1) ? 2 : 1;
      int w = mw(m_mode);
      longint s = longint'(st);
      for (int j = nb - 1; j >= 0; j--) begin
         logic [7:0] b = d[j*8 +: 8];
         logic [7:0] rb;
         if (m_icpl) b = ~b;
         for (int i = 0; i < 8; i++) rb[i] = b[7-i];
         if (m_irev) b = rb;
         for (int i = 7; i >= 0; i--) begin
            int top = int'((s >> (w - 1)) & 1);
            s = (s << 1) & longint'(mmask(w));
            if ((top ^ int'(b[i])) != 0) s = s ^ longint'(mpoly(m_mode));
         end
      end
      return 32'(s);
   endfunction

   function automatic logic [31:0] model_read();
      int w = mw(m_mode);
      logic [31:0] v = m_crc & mmask(w);
      logic [31:0] r = '0;
      for (int i = 0; i < w; i++) r[i] = v[w-1-i];
      if (m_orev) v = r;
      if (m_ocpl) v = ~v & mmask(w);
      return v;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      case (a)
         4'h0: begin
            m_en = d[0]; m_irev = d[24]; m_orev = d[25];
            m_icpl = d[26]; m_ocpl = d[27];
            m_len = int'(d[29:28]); m_mode = int'(d[31:30]);
            if (d[1]) m_crc = m_seed & mmask(mw(m_mode));
         end
         4'h4: if (m_en) m_crc = model_fold(m_crc, d);
         4'h8: m_seed = d;
         default: ;
      endcase
   endtask

   task automatic idle();
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'hC; bus_wdata = '0;
   endtask

   task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 chk(tag, bus_rdata, exp);
   endtask

   task automatic feed_string(); // "123456789" one byte per write (R10)
      for (int c = 1; c <= 9; c++) wr(4'h4, 32'h30 + 32'(c));
   endtask

   // every idle clock: checksum readback against the model (R5, R10)
   always @(negedge clk) begin
      #1;
      if (rst_n && !done && !(bus_sel && bus_wr) && bus_addr == 4'hC)
         chk("R5/R10 continuous", bus_rdata, model_read());
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      rd(4'h0, 32'h0, "R1 ctrl reset");
      rd(4'h8, 32'h0, "R1 seed reset");
      rd(4'hC, 32'h0, "R1 sum reset");
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, 32'hFFFF_FFFF, "R2 seed readback");
      wr(4'hC, 32'h1234_5678);
      rd(4'hC, 32'h0, "R2 sum write ignored");
      wr(4'h4, 32'h31);
      rd(4'hC, 32'h0, "R4 disabled write");
      rd(4'h4, 32'h0, "R1 data reads zero");
      // CRC-32 bytewise
      wr(4'h0, 32'hC000_0003);
      rd(4'h0, 32'hC000_0001, "R3 load bit reads 0");
      rd(4'hC, 32'hFFFF_FFFF, "R3 reload from seed");
      feed_string(); idle();
      rd(4'hC, 32'h0376_E6E7, "R5 crc32 check value");
      wr(4'h0, 32'hC800_0001);
      rd(4'hC, 32'hFC89_1918, "R9 crc32 complemented");
      // whole words then one masked byte
      wr(4'h0, 32'hE000_0003);
      wr(4'h4, 32'h3132_3334);
      wr(4'h4, 32'h3536_3738);
      wr(4'h0, 32'hC000_0001);
      wr(4'h4, 32'hABCD_EF39);
      rd(4'hC, 32'h0376_E6E7, "R6 32-bit words msb first, 8-bit truncation");
      // CCITT 16-bit writes
      wr(4'h0, 32'h1000_0003);
      rd(4'hC, 32'h0000_FFFF, "R3 reload masked to width");
      wr(4'h4, 32'hFFFF_3132); wr(4'h4, 32'h0000_3334);
      wr(4'h4, 32'h1111_3536); wr(4'h4, 32'h0000_3738);
      wr(4'h0, 32'h0000_0001);
      wr(4'h4, 32'h0000_0039);
      rd(4'hC, 32'h0000_29B1, "R5 ccitt check value, R6 16-bit");
      wr(4'h0, 32'h0000_0000);
      wr(4'h4, 32'h0000_0055);
      rd(4'hC, 32'h0000_29B1, "R4 write after disable");
      // CRC-16
      wr(4'h8, 32'h0);
      wr(4'h0, 32'h8000_0003);
      feed_string(); idle();
      rd(4'hC, 32'h0000_FEE8, "R5 crc16 check value");
      // CRC-8 and its output stages
      wr(4'h0, 32'h4000_0003);
      feed_string(); idle();
      rd(4'hC, 32'h0000_00F4, "R5 crc8 check value");
      wr(4'h0, 32'h4800_0001);
      rd(4'hC, 32'h0000_000B, "R9 crc8 complement width only");
      wr(4'h0, 32'h4200_0001);
      rd(4'hC, 32'h0000_002F, "R8 crc8 reverse width only");
      wr(4'h0, 32'h4A00_0001);
      rd(4'hC, 32'h0000_00D0, "R8 R9 crc8 both");
      // 32-bit reverse example
      wr(4'h8, 32'hDD7B_0F2E);
      wr(4'h0, 32'hC200_0003);
      rd(4'hC, 32'h74F0_DEBB, "R8 crc32 reverse");
      // input reversal equivalence
      wr(4'h8, 32'h1234_5678);
      wr(4'h0, 32'hE100_0003);
      wr(4'h4, 32'hAABB_CCDD);
      idle(); saved = model_read();
      rd(4'hC, saved, "R7 reversed input model");
      wr(4'h0, 32'hE000_0003);
      wr(4'h4, 32'h55DD_33BB);
      rd(4'hC, saved, "R7 byte reversal equivalence");
      // complement after truncation, then reversal
      wr(4'h0, 32'hC500_0003);
      wr(4'h4, 32'h0000_FF01);
      idle(); saved = model_read();
      rd(4'hC, saved, "R7 complement+reverse model");
      wr(4'h0, 32'hC000_0003);
      wr(4'h4, 32'h0000_007F);
      rd(4'hC, saved, "R7 complement then reverse equivalence");
      idle(); idle();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule